// File: doc/BRIEF.md
# Eight-bit addressable latch with demultiplexing

The block is a bank of eight single-bit storage cells that software or neighbouring logic writes one bit at a time. A three-bit select picks the cell, a serial data bit supplies its value, an active-high write-disable inhibits writes, and a clear input changes the meaning of the other controls. The eight cells are always presented in parallel, whatever the select and write-disable inputs are doing.

The two control inputs give four modes. With both low, the selected cell is written and the rest keep their contents. With only write-disable high, nothing changes. With both high, every cell is cleared. With only clear high, the bank acts as a 1-of-8 demultiplexer: the selected output takes the data bit and all other outputs are forced to zero. The controls are sampled on the rising clock edge, so outputs move one cycle after the inputs are applied. A two-bit status output reports which mode the last edge applied, and an active-low power-on reset clears the bank asynchronously.

Top module: `bitsel_latch`

## Requirements
- R1: While rst_n is low, q is 0 and mode is 1 (hold), regardless of the clock and of the other inputs.
- R2: At a rising edge with wr_dis=0 and clr=0, q[sel] takes din and every other bit of q keeps its value. mode becomes 0.
- R3: At a rising edge with wr_dis=1 and clr=0, q does not change, for any sel or din value. mode becomes 1.
- R4: At a rising edge with wr_dis=1 and clr=1, every bit of q becomes 0. mode becomes 3.
- R5: At a rising edge with wr_dis=0 and clr=1, q[sel] takes din and every other bit of q becomes 0, so q equals din shifted left by sel. mode becomes 2.
- R6: When the mode moves from demultiplex or clear to hold, q keeps the value set by the last edge of the previous mode.
- R7: sel is a binary index with sel[0] as its least significant bit: value k selects q[k]. q and mode change only at the rising edge that samples the inputs, and both are valid one cycle after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sel | input | 3 | Binary index of the addressed cell |
| din | input | 1 | Data bit for the addressed cell |
| wr_dis | input | 1 | Write-disable, active high |
| clr | input | 1 | Clear input; selects demultiplex or clear-all |
| q | output | 8 | Parallel contents of all cells |
| mode | output | 2 | Mode applied at last edge: 0 write, 1 hold, 2 demux, 3 clear |

## Verification
A mode change and a data update can land on the same edge. In that cycle the cells must follow the incoming mode, while the cells not addressed either keep their old value or drop to zero. The bench provokes this by changing wr_dis or clr at every edge of long runs: write into demux, demux into hold, clear into write. The addressed cell and its data also change at these edges. The scoreboard's reference model judges each cycle against the whole eight-bit word and the status code, so a cell that updates under the wrong mode, or one cycle late, shows up as a mismatch.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  typedef enum logic [1:0] {
    MD_WRITE = 2'd0,
    MD_HOLD  = 2'd1,
    MD_DEMUX = 2'd2,
    MD_CLEAR = 2'd3
  } bsl_mode_e;

  // Two-signal control decode.
  function automatic bsl_mode_e pick_mode(input logic wdis, input logic mclr);
    bsl_mode_e m;
    case ({mclr, wdis})
      2'b00:   m = MD_WRITE;
      2'b01:   m = MD_HOLD;
      2'b10:   m = MD_DEMUX;
      default: m = MD_CLEAR;
    endcase
    return m;
  endfunction

  // Next value of one cell given the mode, its address hit, data and content.
  function automatic logic cell_next(input bsl_mode_e m, input logic hit,
                                     input logic d, input logic cur);
    logic n;
    case (m)
      MD_WRITE: n = hit ? d : cur;
      MD_HOLD:  n = cur;
      MD_DEMUX: n = hit ? d : 1'b0;
      default:  n = 1'b0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bsl_mode_dec.sv
module bsl_mode_dec
  import bsl_pkg::*;
(
  input  logic      wdis,
  input  logic      mclr,
  output bsl_mode_e mode_now,
  output logic      is_write,
  output logic      is_hold,
  output logic      is_demux,
  output logic      is_clear
);

  always_comb begin
    mode_now = pick_mode(wdis, mclr);
    is_write = (mode_now == MD_WRITE);
    is_hold  = (mode_now == MD_HOLD);
    is_demux = (mode_now == MD_DEMUX);
    is_clear = (mode_now == MD_CLEAR);
  end

endmodule

// File: rtl/bsl_addr_dec.sv
module bsl_addr_dec #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [AW-1:0]    sel,
  output logic [WIDTH-1:0] hit
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_hit
    assign hit[i] = (sel == AW'(i));
  end

endmodule

// File: rtl/bsl_cell.sv
module bsl_cell
  import bsl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bsl_mode_e mode_now,
  input  logic      hit,
  input  logic      d,
  output logic      q
);

  logic q_nxt;

  always_comb q_nxt = cell_next(mode_now, hit, d, q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/bitsel_latch.sv
module bitsel_latch
  import bsl_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    sel,
  input  logic             din,
  input  logic             wr_dis,
  input  logic             clr,
  output logic [WIDTH-1:0] q,
  output logic [1:0]       mode
);

  bsl_mode_e        mode_now;
  bsl_mode_e        mode_q;
  logic             is_write, is_hold, is_demux, is_clear;
  logic [WIDTH-1:0] hit;

  bsl_mode_dec u_mode (
    .wdis     (wr_dis),
    .mclr     (clr),
    .mode_now (mode_now),
    .is_write (is_write),
    .is_hold  (is_hold),
    .is_demux (is_demux),
    .is_clear (is_clear)
  );

  bsl_addr_dec #(.WIDTH(WIDTH)) u_addr (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    bsl_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_now (mode_now),
      .hit      (hit[i]),
      .d        (din),
      .q        (q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_HOLD;
    else        mode_q <= mode_now;
  end

  assign mode = mode_q;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(hit)); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_hold |=> $stable(q)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear |=> (q == '0)); // R4
  AST_DEMUX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_demux |=> $onehot0(q)); // R5
  AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    is_write |=> ($countones(q ^ $past(q)) <= 1)); // R2

endmodule

// File: tb/bitsel_latch_bench.sv
module bitsel_latch_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       din = 1'b0;
  logic       wr_dis = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] q;
  logic [1:0] mode;

  int n_run = 0;
  int n_bad = 0;

  typedef struct {
    logic [7:0] q;
    logic [1:0] mode;
    string      req;
  } exp_t;

  exp_t sb[$];
  logic [7:0] m_q = 8'h00;

  always #2.5 clk = ~clk;

  bitsel_latch u_bitsel_latch (
    .clk(clk), .rst_n(rst_n), .sel(sel), .din(din),
    .wr_dis(wr_dis), .clr(clr), .q(q), .mode(mode)
  );

  task automatic check(input logic [7:0] aq, input logic [1:0] am,
                       input logic [7:0] eq, input logic [1:0] em, input string req);
    n_run++;
    if (aq !== eq || am !== em) begin
      n_bad++;
      $display("FAIL %s: q=%h mode=%0d expected q=%h mode=%0d", req, aq, am, eq, em);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes the expected result.
  task automatic step(input logic wd, input logic c, input logic [2:0] s,
                      input logic d, input string req);
    exp_t e;
    logic [1:0] em;
    @(negedge clk);
    wr_dis = wd; clr = c; sel = s; din = d;
    if (!c && !wd)     begin m_q[s] = d; em = 2'd0; end
    else if (!c && wd) begin em = 2'd1; end
    else if (c && !wd) begin m_q = 8'h00; m_q[s] = d; em = 2'd2; end
    else               begin m_q = 8'h00; em = 2'd3; end
    e.q = m_q; e.mode = em; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: compares each result just after the edge that produced it.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(q, mode, e.q, e.mode, e.req);
    end
  end

  initial begin
    #10000000;
    n_run++; n_bad++;
    $display("FAIL watchdog: q=%h mode=%0d expected completion", q, mode);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state while clock runs and inputs try to write
    wr_dis = 1'b0; clr = 1'b0; din = 1'b1; sel = 3'd4;
    repeat (3) @(posedge clk);
    #1 check(q, mode, 8'h00, 2'd1, "R1");
    @(negedge clk);
    wr_dis = 1'b1;
    rst_n = 1'b1;

    // R2/R7: write pattern A5 bit by bit, index k lands on q[k]
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 3'(k), (8'hA5 >> k) & 1'b1, "R7");
    // R3: hold with changing sel and din
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 3'(7 - k), k[0], "R3");
    // R2: overwrite single bits, including rewriting the same bit
    step(1'b0, 1'b0, 3'd1, 1'b1, "R2");
    step(1'b0, 1'b0, 3'd1, 1'b0, "R2");
    step(1'b0, 1'b0, 3'd7, 1'b0, "R2");
    step(1'b0, 1'b0, 3'd6, 1'b1, "R2");
    // R5: demux walking a one, then a zero
    for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), 1'b1, "R5");
    step(1'b0, 1'b1, 3'd3, 1'b0, "R5");
    step(1'b0, 1'b1, 3'd5, 1'b1, "R5");
    // R6: demux into hold keeps last demux value
    step(1'b1, 1'b0, 3'd0, 1'b1, "R6");
    step(1'b1, 1'b0, 3'd2, 1'b0, "R6");
    // R2 from demux result, then R4 clear
    step(1'b0, 1'b0, 3'd0, 1'b1, "R2");
    step(1'b0, 1'b0, 3'd2, 1'b1, "R2");
    step(1'b1, 1'b1, 3'd2, 1'b1, "R4");
    // R6: clear into hold stays zero
    step(1'b1, 1'b0, 3'd4, 1'b1, "R6");
    // mode change every edge
    step(1'b0, 1'b0, 3'd3, 1'b1, "R2");
    step(1'b0, 1'b1, 3'd6, 1'b1, "R5");
    step(1'b1, 1'b0, 3'd1, 1'b0, "R6");
    step(1'b0, 1'b0, 3'd0, 1'b1, "R2");
    step(1'b1, 1'b1, 3'd0, 1'b1, "R4");
    step(1'b0, 1'b0, 3'd7, 1'b1, "R2");
    step(1'b0, 1'b1, 3'd7, 1'b0, "R5");
    step(1'b1, 1'b0, 3'd7, 1'b1, "R3");
    // R7: output does not move between edges
    @(negedge clk);
    wr_dis = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(q, mode, m_q, 2'd1, "R7");

    // R1: asynchronous reset mid-cycle after loading a value
    step(1'b0, 1'b0, 3'd5, 1'b1, "R2");
    @(negedge clk);
    wr_dis = 1'b1;
    #1 rst_n = 1'b0;
    #0.5 check(q, mode, 8'h00, 2'd1, "R1");
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule